// File: doc/BRIEF.md
# Four-Bit Event Counter with Overflow Interrupt

This block keeps a small wrapping count of clock events taken from one of three selectable sources: a software strobe, a timer compare-match pulse, or an external clock pin. The external clock is brought into the block's clock domain through a synchroniser, and any change of its level, rising or falling, counts as one event. When the count rolls over from its highest value back to zero, a sticky overflow flag is set, an interrupt request follows the flag whenever the interrupt is enabled, and a one-cycle carry pulse leaves the block to step an external timer. With the default four-bit width, the counter and an eight-bit timer together give a twelve-bit count.

The host may load the count at any time. Loading the highest value makes the very next event overflow. With the external clock selected, this turns the block into an edge-triggered interrupt input, and with the software strobe selected it gives a software-raised interrupt. The host clears the flag by pulsing a clear input.

Top module: `nib_evt_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count, overflow flag, carry and interrupt request all become 0.
- R2: With `src_sel` = 2'b01 (software), every cycle with `sw_strobe` high adds 1 to the count, and `tmr_match` has no effect.
- R3: With `src_sel` = 2'b10 (timer), every cycle with `tmr_match` high adds 1 to the count, and `sw_strobe` has no effect.
- R4: With `src_sel` = 2'b11 (external), each rising and each falling transition of `ext_clk` adds 1 to the count. The new count is visible after the third rising clock edge that follows the transition, and not after the second.
- R5: With `src_sel` = 2'b00, the count does not change on strobes, timer matches or `ext_clk` transitions.
- R6: An increment from 15 (the all-ones count) gives 0, sets `ovf_flag`, and drives `carry_out` high for exactly one cycle.
- R7: A cycle with `cnt_wr` high loads `cnt_wdata` into the count. This takes precedence over an increment in the same cycle.
- R8: A cycle with `flag_clr` high clears `ovf_flag`, unless an overflow happens in the same cycle, in which case the flag stays set.
- R9: `irq` is high exactly when `ovf_flag` and `irq_en` are both high.
- R10: After the count is loaded with 15, a single external clock transition raises `ovf_flag` and, when enabled, `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 2 | Event source: 00 off, 01 software, 10 timer, 11 external clock |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| tmr_match | input | 1 | Timer compare-match pulse |
| sw_strobe | input | 1 | Software count strobe |
| cnt_wr | input | 1 | Load the count this cycle |
| cnt_wdata | input | 4 | Value to load |
| flag_clr | input | 1 | Clear the overflow flag this cycle |
| irq_en | input | 1 | Interrupt enable |
| cnt_q | output | 4 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| carry_out | output | 1 | One-cycle pulse on each wrap, for the cascaded timer |

## Verification
The count is visible directly at the ports. A lost or doubled increment therefore shows up at the next observation, one cycle after a strobe or timer event and three cycles after an external transition. A wrong synchroniser or edge detector shows up as a count that lags, runs ahead, or moves on only one polarity of the external clock. Errors in the flag logic show up within one cycle: a flag that is not sticky, a clear that wins over a coincident wrap, or a carry that lasts longer than one cycle. Directed sequences load 14 or 15 before each wrap, so every overflow case is reached in at most two events.

// File: rtl/nec_pkg.sv
// Package: shared types for the four-bit event counter.
// Assumes: the src_sel encoding below is fixed by the block's requirements.
package nec_pkg;
    typedef enum logic [1:0] {
        SRC_OFF    = 2'b00,
        SRC_SOFT   = 2'b01,
        SRC_TIMER  = 2'b10,
        SRC_EXTCLK = 2'b11
    } evt_src_e;
endpackage

// File: rtl/evt_source_sel.sv
// Module: evt_source_sel
// Brings the external clock into the clk domain through a synchroniser and
// reports each change of its level as an event. Selects one event source.
// Assumes: ext_clk stays at each level for at least SYNC_STAGES+1 clk cycles.
module evt_source_sel
    import nec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  evt_src_e src,
    input  logic     ext_clk,
    input  logic     tmr_match,
    input  logic     sw_strobe,
    output logic     evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_edge;

    // Synchroniser chain for the asynchronous clock pin.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= ext_clk;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Any change of level, in either direction, is one event.
    assign ext_edge = sync_q[LAST] ^ prev_q;

    // Choose the event source.
    always_comb begin
        unique case (src)
            SRC_SOFT:   evt = sw_strobe;
            SRC_TIMER:  evt = tmr_match;
            SRC_EXTCLK: evt = ext_edge;
            default:    evt = 1'b0;
        endcase
    end

    // R5
    off_src_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OFF) |-> !evt);
    // R4
    edge_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXTCLK && sync_q[LAST] != prev_q) |-> evt);
endmodule

// File: rtl/cnt_core.sv
// Module: cnt_core
// Wrapping up-counter with a host load and a registered one-cycle carry.
// Assumes: a load wins over an increment in the same cycle.
module cnt_core #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             carry
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // A wrap happens on an increment from the top value that no load overrides.
    assign wrap = inc && !wr && (cnt == CNT_MAX);

    // Count register: a load has priority, otherwise increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (wr)  cnt <= wdata;
        else if (inc) cnt <= cnt + CNT_ONE;
    end

    // Carry pulse that steps the cascaded timer.
    always_ff @(posedge clk) begin
        if (!rst_n) carry <= 1'b0;
        else        carry <= wrap;
    end

    // R7
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata)));
    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && cnt == CNT_MAX) |=> (cnt == '0 && carry));
    // R6
    carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/ovf_flag_ctl.sv
// Module: ovf_flag_ctl
// Sticky overflow flag with a clear input and an interrupt request gate.
// Assumes: a set in the same cycle as a clear leaves the flag set.
module ovf_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Flag register: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // The interrupt request follows the flag while it is enabled.
    assign irq = flag && irq_en;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);
endmodule

// File: rtl/nib_evt_counter.sv
// Module: nib_evt_counter (top)
// Four-bit event counter. It counts software strobes, timer matches or both
// edges of an external clock, keeps a sticky overflow flag with an interrupt
// request, and outputs a carry pulse for a cascaded timer.
// Assumes: synchronous active-low reset; host inputs are clk-synchronous.
module nib_evt_counter
    import nec_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             ext_clk,
    input  logic             tmr_match,
    input  logic             sw_strobe,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             irq,
    output logic             carry_out
);
    logic evt;
    logic wrap;

    evt_source_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (evt_src_e'(src_sel)),
        .ext_clk   (ext_clk),
        .tmr_match (tmr_match),
        .sw_strobe (sw_strobe),
        .evt       (evt)
    );

    cnt_core #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt),
        .wr    (cnt_wr),
        .wdata (cnt_wdata),
        .cnt   (cnt_q),
        .wrap  (wrap),
        .carry (carry_out)
    );

    ovf_flag_ctl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (wrap),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (ovf_flag),
        .irq    (irq)
    );

    // R6
    wrap_flag_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (ovf_flag && cnt_q == '0));
endmodule

// File: tb/sim_nib_evt_counter.sv
module sim_nib_evt_counter;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       ext_clk = 1'b0;
    logic       tmr_match = 1'b0;
    logic       sw_strobe = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [3:0] cnt_wdata = 4'd0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic [3:0] cnt_q;
    logic       ovf_flag, irq, carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_evt_counter u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_clk(ext_clk),
        .tmr_match(tmr_match), .sw_strobe(sw_strobe), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq), .carry_out(carry_out)
    );

    // Vector layout: req[21:18] src[17:16] stb[15] tmr[14] wr[13] data[12:9]
    // clr[8] en[7] | expected cnt[6:3] flag[2] carry[1] irq[0]
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd2,  2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b0, 1'b0, 1'b0}, // R2 strobe
        {4'd2,  2'd1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b0, 1'b0, 1'b0}, // R2 timer ignored
        {4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd2,  1'b0, 1'b0, 1'b0}, // R3 timer
        {4'd3,  2'd2, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd2,  1'b0, 1'b0, 1'b0}, // R3 strobe ignored
        {4'd5,  2'd0, 1'b1, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd2,  1'b0, 1'b0, 1'b0}, // R5 off
        {4'd7,  2'd1, 1'b1, 1'b0, 1'b1, 4'd14, 1'b0, 1'b0, 4'd14, 1'b0, 1'b0, 1'b0}, // R7 load wins
        {4'd2,  2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd15, 1'b0, 1'b0, 1'b0}, // R2
        {4'd6,  2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 1'b0}, // R6 wrap
        {4'd9,  2'd1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 1'b1}, // R9 enable
        {4'd8,  2'd1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0}, // R8 clear
        {4'd7,  2'd1, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 1'b0}, // R7 preset
        {4'd8,  2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 1'b1}, // R8 set wins
        {4'd8,  2'd1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0}, // R8 clear
        {4'd7,  2'd2, 1'b1, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 4'd3,  1'b0, 1'b0, 1'b0}, // R7
        {4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0}  // R3
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle();
        sw_strobe = 0; tmr_match = 0; cnt_wr = 0; flag_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clocks(3);
        // R1 reset state
        check("R1", "cnt", cnt_q, 0);
        check("R1", "flag", ovf_flag, 0);
        check("R1", "carry", carry_out, 0);
        check("R1", "irq", irq, 0);
        rst_n = 1;

        for (int v = 0; v < NVEC; v++) begin
            logic [21:0] e;
            string r;
            e = VEC[v];
            r = $sformatf("R%0d", e[21:18]);
            src_sel = e[17:16]; sw_strobe = e[15]; tmr_match = e[14];
            cnt_wr = e[13]; cnt_wdata = e[12:9]; flag_clr = e[8]; irq_en = e[7];
            clocks(1);
            check(r, $sformatf("vec%0d cnt", v), cnt_q, e[6:3]);
            check(r, $sformatf("vec%0d flag", v), ovf_flag, e[2]);
            check(r, $sformatf("vec%0d carry", v), carry_out, e[1]);
            check(r, $sformatf("vec%0d irq", v), irq, e[0]);
        end
        idle();

        // R4 both edges of the external clock, three-cycle latency
        src_sel = 2'b11; irq_en = 1; flag_clr = 1; cnt_wr = 1; cnt_wdata = 4'd14;
        clocks(1);
        idle();
        ext_clk = 1;
        clocks(2);
        check("R4", "rise not yet", cnt_q, 14);
        clocks(1);
        check("R4", "rise counted", cnt_q, 15);
        clocks(2);
        check("R4", "no extra count", cnt_q, 15);
        // R10 preset 15, one falling transition raises the interrupt
        ext_clk = 0;
        clocks(3);
        check("R4", "fall counted", cnt_q, 0);
        check("R10", "flag", ovf_flag, 1);
        check("R10", "irq", irq, 1);
        check("R6", "carry high", carry_out, 1);
        clocks(1);
        check("R6", "carry one cycle", carry_out, 0);
        check("R8", "flag sticky", ovf_flag, 1);

        // R10 with a rising transition after a preset to 15
        flag_clr = 1; cnt_wr = 1; cnt_wdata = 4'd15;
        clocks(1);
        idle();
        check("R10", "flag cleared", ovf_flag, 0);
        ext_clk = 1;
        clocks(3);
        check("R10", "rise irq", irq, 1);
        irq_en = 0;
        clocks(1);
        check("R9", "irq masked", irq, 0);

        // R5 off: external transitions are ignored
        src_sel = 2'b00;
        ext_clk = 0;
        clocks(4);
        ext_clk = 1;
        clocks(4);
        check("R5", "ext ignored", cnt_q, 0);

        // R1 synchronous reset in mid-run
        src_sel = 2'b01; cnt_wr = 1; cnt_wdata = 4'd9;
        clocks(1);
        idle();
        rst_n = 0;
        clocks(1);
        check("R1", "mid cnt", cnt_q, 0);
        check("R1", "mid flag", ovf_flag, 0);
        rst_n = 1;
        clocks(1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule